// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Sequencer

This block sits behind a two-wire serial slave controller in a small non-volatile memory. The controller hands it decoded events as single-cycle strobes: a start condition, a loaded word address, a received data byte, a valid stop condition and a read-byte request. Data bytes are gathered into a page latch of up to `2**PAGE_W` bytes and are committed to the storage array only when a stop closes a write sequence that carried at least one byte.

A commit opens a self-timed program window whose length is set from a clock-frequency parameter and a write-time parameter (10 ms by default). The busy output stays high for the whole window, and the controller uses it to stop acknowledging its address, so the master detects completion by polling for an acknowledge. A write-protect input, sampled at the commit, keeps the upper half of the address space read-only. The program step itself is modelled as a walk through the latch slots, one array write per cycle, after the timer expires.

A single address counter serves both directions. Page loading advances only its in-page bits, so a write stays inside its page. Reads advance every bit and roll over at the top of memory.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy_o` is 0, `addr_o` is 0 and `rd_data_o` is 0.
- R2: A data strobe while idle stores the byte in the page slot chosen by the low `PAGE_W` bits of the address counter. It then advances only those low bits by one, and the page bits stay unchanged.
- R3: A sequence with more than `2**PAGE_W` data bytes wraps to the start of the same page, and each later byte replaces the byte held in its slot.
- R4: A stop while idle with at least one latched byte raises `busy_o` on the next cycle. `busy_o` stays high for exactly `TWR_CYC + 2**PAGE_W` cycles, where `TWR_CYC = (CLK_HZ/1_000_000)*TWR_US`.
- R5: A stop that follows zero data bytes, or a sequence cut off by a new start before its stop, commits nothing and leaves `busy_o` low.
- R6: While `busy_o` is high, every strobe input (start, address load, data, stop, read) is ignored. The address counter and the array are unchanged by them.
- R7: If `wp_i` is 1 at the commit and the page lies in the upper half (address MSB = 1), no byte of that page is changed. Lower-half pages are written whatever the value of `wp_i`.
- R8: A commit changes only the slots loaded in that sequence. The other bytes of the page keep their contents.
- R9: After a commit, `addr_o` points to the slot after the last one loaded, within the same page.
- R10: A read strobe while idle with no address load or data strobe sets `rd_data_o` on the next cycle to the byte at the counter address. The counter then advances over all bits and rolls from the top address to 0.
- R11: `wp_i` matters only in the commit cycle. Its value during loading or during the busy window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write protect for the upper half of memory |
| start_i | input | 1 | Start or repeated-start strobe; discards the latch |
| addr_load_i | input | 1 | Word-address strobe |
| addr_i | input | ADDR_W | Word address loaded by `addr_load_i` |
| wr_i | input | 1 | Data byte strobe |
| wr_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Valid stop condition strobe |
| rd_i | input | 1 | Read-byte request |
| rd_data_o | output | DATA_W | Byte read, valid the cycle after `rd_i` |
| addr_o | output | ADDR_W | Shared address counter |
| busy_o | output | 1 | Program window active; bus must not respond |

## Verification
A stale or wrong page latch shows up at the ports only after the program window ends, as wrong bytes on readback. The bench therefore reads back each touched page and its neighbours once the block is idle again. A counter that drifts out of its page is visible on `addr_o` in the very next cycle. A timer off by one shows as a `busy_o` fall one cycle early or late. A protect flag taken at the wrong moment only shows on readback, so `wp_i` is toggled both before the stop and inside the busy window.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PROG = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pgw_page_latch.sv
module pgw_page_latch #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_o
);
  localparam int unsigned SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  valid_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_slot_i == PAGE_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[s]  <= '0;
        valid_q[s] <= 1'b0;
      end else if (clr_i) begin
        valid_q[s] <= 1'b0;
      end else if (hit) begin
        data_q[s]  <= wr_data_i;
        valid_q[s] <= 1'b1;
      end
    end
  end

  assign rd_data_o  = data_q[rd_slot_i];
  assign rd_valid_o = valid_q[rd_slot_i];
  assign any_o      = |valid_q;
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pgw_mem.sv
module pgw_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned TWR_US = 10_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stop_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);
  import pgw_pkg::*;

  localparam int unsigned TWR_CYC  = (CLK_HZ / 1_000_000) * TWR_US;
  localparam int unsigned TMR_CYC  = (TWR_CYC < 1) ? 1 : TWR_CYC;
  localparam int unsigned PAGE_N   = 1 << PAGE_W;
  localparam int unsigned BUSY_CYC = TMR_CYC + PAGE_N;
  localparam int unsigned PG_W     = ADDR_W - PAGE_W;

  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] idx_q;
  logic              prot_q;

  logic              accept;
  logic              do_load, do_wr, do_rd;
  logic              commit, prog_done, tmr_done;
  logic              slot_any, slot_valid;
  logic [DATA_W-1:0] slot_data;
  logic              latch_clr;
  logic              mem_we;

  assign accept  = (state_q == ST_IDLE);
  assign do_load = accept && addr_load_i;
  assign do_wr   = accept && wr_i && !addr_load_i;
  assign do_rd   = accept && rd_i && !addr_load_i && !wr_i;
  assign commit  = accept && stop_i && slot_any;

  assign prog_done = (state_q == ST_PROG) && (idx_q == '1);
  assign latch_clr = (accept && start_i) || prog_done;

  // shared address counter: page-local on writes, full width on reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (do_load) begin
      addr_q <= addr_i;
    end else if (do_wr) begin
      addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
    end else if (do_rd) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      page_q  <= '0;
      prot_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (commit) begin
          state_q <= ST_WAIT;
          page_q  <= addr_q[ADDR_W-1:PAGE_W];
          prot_q  <= wp_i && addr_q[ADDR_W-1];
        end
        ST_WAIT: if (tmr_done) begin
          state_q <= ST_PROG;
          idx_q   <= '0;
        end
        ST_PROG: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pgw_page_latch #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (latch_clr),
    .wr_i       (do_wr),
    .wr_slot_i  (addr_q[PAGE_W-1:0]),
    .wr_data_i  (wr_data_i),
    .rd_slot_i  (idx_q),
    .rd_data_o  (slot_data),
    .rd_valid_o (slot_valid),
    .any_o      (slot_any)
  );

  pgw_timer #(
    .CYCLES (TMR_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .done_o  (tmr_done)
  );

  assign mem_we = (state_q == ST_PROG) && slot_valid && !prot_q;

  pgw_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mem_we),
    .wr_addr_i ({page_q, idx_q}),
    .wr_data_i (slot_data),
    .rd_en_i   (do_rd),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data_o)
  );

  assign addr_o = addr_q;
  assign busy_o = !accept;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned BUSY_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_load_i,
  input logic              wr_i,
  input logic              stop_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              any_i
);
  logic [31:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  // R2
  page_local_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_load_i && !busy_o) |=>
      (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])) &&
      (addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1'b1)));

  // R4
  busy_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  // R4
  busy_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == BUSY_CYC));

  // R5
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !any_i) |=> !busy_o);

  // R6
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o));

  // R10
  read_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !addr_load_i && !busy_o) |=>
      (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
endmodule

bind page_write_seq pgw_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_W   (PAGE_W),
  .BUSY_CYC (BUSY_CYC)
) u_pgw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_load_i (addr_load_i),
  .wr_i        (wr_i),
  .stop_i      (stop_i),
  .rd_i        (rd_i),
  .addr_o      (addr_o),
  .busy_o      (busy_o),
  .any_i       (slot_any)
);

// File: tb/page_write_seq_test.sv
`timescale 1ns/1ps
module page_write_seq_test;
  localparam int AW = 7;
  localparam int PW = 4;
  localparam int DW = 8;
  localparam int TWR = 20;
  localparam int BUSY = TWR + (1 << PW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, start = 1'b0, aload = 1'b0, wr = 1'b0, stop = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] addr_o;
  logic busy_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  page_write_seq #(
    .ADDR_W (AW), .PAGE_W (PW), .DATA_W (DW),
    .CLK_HZ (1_000_000), .TWR_US (TWR)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .wp_i (wp), .start_i (start),
    .addr_load_i (aload), .addr_i (addr), .wr_i (wr), .wr_data_i (wdata),
    .stop_i (stop), .rd_i (rd), .rd_data_o (rd_data_o), .addr_o (addr_o),
    .busy_o (busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0]    m_mem [1 << AW];
  logic [PW+DW-1:0] m_q [$];
  logic [AW-1:0]    m_addr;
  logic [DW-1:0]    m_rd;
  logic [AW-PW-1:0] m_page;
  logic             m_wp;
  int               m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = '0; m_rd = '0; m_left = 0; m_wp = 1'b0; m_page = '0;
      m_q.delete();
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        foreach (m_q[i])
          if (!(m_wp && m_page[AW-PW-1])) m_mem[{m_page, m_q[i][PW+DW-1:DW]}] = m_q[i][DW-1:0];
        m_q.delete();
      end
    end else begin
      if (start) m_q.delete();
      if (aload) m_addr = addr;
      else if (wr) begin
        m_q.push_back({m_addr[PW-1:0], wdata});
        m_addr[PW-1:0] = m_addr[PW-1:0] + 1'b1;
      end else if (rd) begin
        m_rd = m_mem[m_addr];
        m_addr = m_addr + 1'b1;
      end
      if (stop && m_q.size() > 0) begin
        m_left = BUSY; m_wp = wp; m_page = m_addr[AW-1:PW];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o === (m_left > 0), "R4 busy", int'(busy_o), int'(m_left > 0));
      chk(addr_o === m_addr, "R9 addr", int'(addr_o), int'(m_addr));
      chk(rd_data_o === m_rd, "R10 rd_data", int'(rd_data_o), int'(m_rd));
    end
  end

  function automatic logic [DW-1:0] fv(input int a);
    return DW'(a * 3 + 1);
  endfunction

  task automatic do_start; start = 1'b1; @(negedge clk); start = 1'b0; endtask
  task automatic do_stop;  stop  = 1'b1; @(negedge clk); stop  = 1'b0; endtask
  task automatic do_rd;    rd    = 1'b1; @(negedge clk); rd    = 1'b0; endtask
  task automatic do_load(input int a);
    addr = AW'(a); aload = 1'b1; @(negedge clk); aload = 1'b0;
  endtask
  task automatic do_wr(input logic [DW-1:0] d);
    wdata = d; wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask
  task automatic page_write(input int a, input int n, input int seed, output int blen);
    do_start; do_load(a);
    for (int k = 0; k < n; k++) do_wr(DW'(seed + k));
    do_stop;
    wait_idle(blen);
  endtask
  task automatic read_at(input int a);
    do_start; do_load(a); do_start; do_rd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    // R1
    chk(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
    chk(addr_o === '0, "R1 addr", int'(addr_o), 0);
    chk(rd_data_o === '0, "R1 rd_data", int'(rd_data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill all pages; R4 busy length
    for (int p = 0; p < (1 << (AW - PW)); p++) begin
      do_start; do_load(p << PW);
      for (int k = 0; k < (1 << PW); k++) do_wr(fv((p << PW) + k));
      do_stop;
      chk(busy_o === 1'b1, "R4 busy rise", int'(busy_o), 1);
      wait_idle(blen);
      chk(blen == BUSY, "R4 busy length", blen, BUSY);
    end

    // R2, R8, R9: partial page
    page_write(8'h13, 3, 8'hC0, blen);
    chk(addr_o === 7'h16, "R9 next slot", int'(addr_o), 'h16);
    read_at(8'h12);
    chk(rd_data_o === fv('h12), "R8 untouched before", int'(rd_data_o), int'(fv('h12)));
    do_rd; chk(rd_data_o === 8'hC0, "R2 slot 3", int'(rd_data_o), 'hC0);
    do_rd; do_rd; chk(rd_data_o === 8'hC2, "R2 slot 5", int'(rd_data_o), 'hC2);
    do_rd; chk(rd_data_o === fv('h16), "R8 untouched after", int'(rd_data_o), int'(fv('h16)));

    // R3: 18 bytes from slot 14 wrap in page
    page_write(8'h2E, 18, 8'h80, blen);
    chk(addr_o === 7'h20, "R3 addr wraps in page", int'(addr_o), 'h20);
    read_at(8'h2E);
    chk(rd_data_o === 8'h90, "R3 overwrite slot 14", int'(rd_data_o), 'h90);
    read_at(8'h20);
    chk(rd_data_o === 8'h82, "R3 slot 0", int'(rd_data_o), 'h82);
    read_at(8'h2D);
    chk(rd_data_o === 8'h8F, "R3 slot 13", int'(rd_data_o), 'h8F);

    // R5: empty sequence and aborted sequence
    do_start; do_load(8'h30); do_stop;
    chk(busy_o === 1'b0, "R5 empty stop", int'(busy_o), 0);
    do_start; do_load(8'h30); do_wr(8'h5A); do_start; do_stop;
    chk(busy_o === 1'b0, "R5 aborted stop", int'(busy_o), 0);
    read_at(8'h30);
    chk(rd_data_o === fv('h30), "R5 no commit", int'(rd_data_o), int'(fv('h30)));

    // R6: strobes during busy
    do_start; do_load(8'h40); do_wr(8'h11); do_wr(8'h12); do_stop;
    do_load(8'h05); do_wr(8'hEE); do_rd; do_start; do_stop;
    chk(addr_o === 7'h42, "R6 addr frozen", int'(addr_o), 'h42);
    wait_idle(blen);
    chk(blen == BUSY - 5, "R6 busy not extended", blen, BUSY - 5);
    read_at(8'h05);
    chk(rd_data_o === fv('h05), "R6 data ignored", int'(rd_data_o), int'(fv('h05)));

    // R7: protection
    wp = 1'b1;
    page_write(8'h50, 4, 8'h10, blen);
    read_at(8'h50);
    chk(rd_data_o === fv('h50), "R7 upper protected", int'(rd_data_o), int'(fv('h50)));
    page_write(8'h08, 1, 8'h77, blen);
    read_at(8'h08);
    chk(rd_data_o === 8'h77, "R7 lower written", int'(rd_data_o), 'h77);

    // R11: protect sampled only at commit
    do_start; do_load(8'h60); do_wr(8'h31); wp = 1'b0; do_stop;
    wp = 1'b1;
    wait_idle(blen);
    do_start; do_load(8'h61); do_wr(8'h32); wp = 1'b0; do_stop;
    wp = 1'b1; @(negedge clk); wp = 1'b0;
    wait_idle(blen);
    read_at(8'h60);
    chk(rd_data_o === 8'h31, "R11 wp during load", int'(rd_data_o), 'h31);
    do_rd;
    chk(rd_data_o === 8'h32, "R11 wp during busy", int'(rd_data_o), 'h32);

    // R10: sequential read rollover
    read_at(8'h7F);
    chk(rd_data_o === fv('h7F), "R10 top byte", int'(rd_data_o), int'(fv('h7F)));
    do_rd;
    chk(rd_data_o === fv('h00), "R10 rollover byte", int'(rd_data_o), int'(fv('h00)));
    chk(addr_o === 7'h01, "R10 rollover addr", int'(addr_o), 1);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule